// File: doc/BRIEF.md
# Silent-Store Suppressing Write-Back Cache

This block is a small direct-mapped write-back data cache. It sits between a CPU-side load/store port and a next-level memory that moves whole lines. What sets it apart is how it decides whether a line is dirty. A store that hits does not mark the line modified at once. The controller first reads the old word and compares it with the incoming bytes, but only in the byte lanes the store enables. It then writes the word and sets the dirty bit only if at least one enabled byte really changes.

A store that changes nothing is a silent store. It leaves the line clean and increments a visible counter. When a clean line is later evicted, it is simply overwritten and no write-back goes to memory. Each line also keeps an all-zero flag, which is recomputed on every refill and every store write. A zero store into an all-zero line is therefore resolved from the flag as silent, without looking at the old data.

A miss with a dirty victim first writes the victim line out, then reads the new line. A miss with a clean or invalid victim only reads the new line. After the refill the request is looked up again and completes as a hit.

Top module: `silent_store_cache`

## Requirements
- R1: A load that hits returns the addressed 32-bit word with `rsp_valid` high for one cycle, in the second cycle after the request is accepted. The word is selected by address bits [3:2].
- R2: A store that hits spends one cycle on compare and one cycle on write. Its completion pulse on `rsp_valid` comes in the third cycle after acceptance. `req_ready` is low from the cycle after acceptance until the request completes.
- R3: A store that changes at least one enabled byte marks the line dirty. When that line is evicted, it is written back with the merged data, where byte b of a word belongs to byte-enable bit b.
- R4: A store whose enabled bytes all equal the stored bytes leaves the line clean and increments `silent_count` by one. Evicting that line causes no memory write.
- R5: Bytes whose byte-enable bit is 0 are neither written nor compared. A store that differs from the stored word only in disabled lanes is silent.
- R6: A store of zeros into a line that is entirely zero is silent, and the line causes no write-back.
- R7: A miss whose victim is valid and dirty issues a memory write of the victim line first, at line address {victim tag, index}. Only after that write is acknowledged does it issue the refill read.
- R8: A miss whose victim is clean or invalid issues only a refill read.
- R9: After reset, `req_ready` is 1, `rsp_valid` and `mem_valid` are 0, and `silent_count` is 0.
- R10: Once raised, a memory request holds its kind and address until `mem_ack`. A write is followed by the refill read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| req_wdata | input | WORD_W | Store data |
| req_be | input | WORD_W/8 | Store byte enables |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Load data, valid with `rsp_valid` |
| silent_count | output | CNT_W | Count of stores found silent |
| mem_valid | output | 1 | Memory request present |
| mem_write | output | 1 | 1 for line write-back, 0 for refill read |
| mem_line_addr | output | ADDR_W-OFF_W | Line address of the memory request |
| mem_wline | output | LINE_WORDS*WORD_W | Line data for a write-back |
| mem_ack | input | 1 | Memory completes the request |
| mem_rline | input | LINE_WORDS*WORD_W | Refill data, valid with `mem_ack` |

## Verification
The bench builds the cache with a 10-bit address, 32-bit words, four words per line and only two sets. With so few sets, a handful of addresses is enough to force evictions, so every line's clean or dirty state shows up at the memory port within a few operations. Every eighth memory line starts all zero, which brings the zero-over-zero path within reach. Random stores that reuse the resident word half the time, together with random byte masks, exercise both silent and changing stores under partial enables.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WRITE,
        ST_EVICT,
        ST_FILL
    } ssc_state_e;
endpackage

// File: rtl/ssc_byte_diff.sv
// Decides whether a store changes any enabled byte of the old word.
module ssc_byte_diff #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]   old_word,
    input  logic [WORD_W-1:0]   new_word,
    input  logic [WORD_W/8-1:0] be,
    input  logic                line_zero,
    output logic                changed
);
    localparam int NB = WORD_W / 8;
    logic [NB-1:0] lane_diff;
    logic [NB-1:0] lane_nz;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lane_diff[b] = be[b] && (old_word[b*8 +: 8] != new_word[b*8 +: 8]);
        assign lane_nz[b]   = be[b] && (new_word[b*8 +: 8] != 8'h00);
    end

    // A line known to be zero needs no old-data read: only non-zero writes change it.
    assign changed = line_zero ? |lane_nz : |lane_diff;
endmodule

// File: rtl/ssc_word_merge.sv
// Inserts the enabled bytes of one word into a line.
module ssc_word_merge #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic [LINE_WORDS*WORD_W-1:0]   line_in,
    input  logic [$clog2(LINE_WORDS)-1:0]  wsel,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [WORD_W/8-1:0]            be,
    output logic [LINE_WORDS*WORD_W-1:0]   line_out
);
    localparam int NB = WORD_W / 8;

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign line_out[w*WORD_W + b*8 +: 8] =
                (wsel == w[$clog2(LINE_WORDS)-1:0] && be[b]) ? wdata[b*8 +: 8]
                                                            : line_in[w*WORD_W + b*8 +: 8];
        end
    end
endmodule

// File: rtl/ssc_zero_detect.sv
module ssc_zero_detect #(
    parameter int W = 128
) (
    input  logic [W-1:0] vec,
    output logic         all_zero
);
    assign all_zero = (vec == '0);
endmodule

// File: rtl/silent_store_cache.sv
module silent_store_cache
    import ssc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 4,
    parameter int CNT_W      = 16,
    localparam int NB        = WORD_W / 8,
    localparam int BYTE_W    = $clog2(NB),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int OFF_W     = BYTE_W + WSEL_W,
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W    = LINE_WORDS * WORD_W,
    localparam int LADDR_W   = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [NB-1:0]      req_be,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic [CNT_W-1:0]   silent_count,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [LADDR_W-1:0] mem_line_addr,
    output logic [LINE_W-1:0]  mem_wline,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rline
);
    typedef struct packed {
        ssc_state_e                   state;
        logic [SETS-1:0]              valid;
        logic [SETS-1:0]              dirty;
        logic [SETS-1:0]              zero;
        logic [SETS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][LINE_W-1:0]  data;
        logic                         op_write;
        logic [ADDR_W-1:0]            op_addr;
        logic [WORD_W-1:0]            op_wdata;
        logic [NB-1:0]                op_be;
        logic                         changed;
        logic                         rsp_valid;
        logic [WORD_W-1:0]            rsp_rdata;
        logic [CNT_W-1:0]             silent_cnt;
    } ctl_t;

    ctl_t q, d;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  op_tag;
    logic [WSEL_W-1:0] wsel;
    logic              hit;
    logic [WORD_W-1:0] old_word;
    logic              store_changes;
    logic [LINE_W-1:0] merged_line;
    logic              merged_zero;
    logic              fill_zero;

    assign idx      = q.op_addr[OFF_W +: IDX_W];
    assign op_tag   = q.op_addr[ADDR_W-1 -: TAG_W];
    assign wsel     = q.op_addr[BYTE_W +: WSEL_W];
    assign hit      = q.valid[idx] && (q.tag[idx] == op_tag);
    assign old_word = q.data[idx][wsel*WORD_W +: WORD_W];

    ssc_byte_diff #(.WORD_W(WORD_W)) i_diff (
        .old_word (old_word),
        .new_word (q.op_wdata),
        .be       (q.op_be),
        .line_zero(q.zero[idx]),
        .changed  (store_changes)
    );

    ssc_word_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) i_merge (
        .line_in (q.data[idx]),
        .wsel    (wsel),
        .wdata   (q.op_wdata),
        .be      (q.op_be),
        .line_out(merged_line)
    );

    ssc_zero_detect #(.W(LINE_W)) i_zero_merged (.vec(merged_line), .all_zero(merged_zero));
    ssc_zero_detect #(.W(LINE_W)) i_zero_fill   (.vec(mem_rline),   .all_zero(fill_zero));

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op_write = req_write;
                    d.op_addr  = req_addr;
                    d.op_wdata = req_wdata;
                    d.op_be    = req_be;
                    d.state    = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (hit) begin
                    if (q.op_write) begin
                        d.changed = store_changes;
                        d.state   = ST_WRITE;
                    end else begin
                        d.rsp_valid = 1'b1;
                        d.rsp_rdata = old_word;
                        d.state     = ST_IDLE;
                    end
                end else if (q.valid[idx] && q.dirty[idx]) begin
                    d.state = ST_EVICT;
                end else begin
                    d.state = ST_FILL;
                end
            end
            ST_WRITE: begin
                d.data[idx] = merged_line;
                d.zero[idx] = merged_zero;
                if (q.changed) begin
                    d.dirty[idx] = 1'b1;
                end else begin
                    d.silent_cnt = q.silent_cnt + 1'b1;
                end
                d.rsp_valid = 1'b1;
                d.state     = ST_IDLE;
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    d.dirty[idx] = 1'b0;
                    d.state      = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    d.data[idx]  = mem_rline;
                    d.tag[idx]   = op_tag;
                    d.valid[idx] = 1'b1;
                    d.dirty[idx] = 1'b0;
                    d.zero[idx]  = fill_zero;
                    d.state      = ST_LOOK;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_valid     = (q.state == ST_EVICT) || (q.state == ST_FILL);
        mem_write     = (q.state == ST_EVICT);
        mem_line_addr = (q.state == ST_EVICT) ? {q.tag[idx], idx} : {op_tag, idx};
        mem_wline     = q.data[idx];
    end

    assign req_ready    = (q.state == ST_IDLE);
    assign rsp_valid    = q.rsp_valid;
    assign rsp_rdata    = q.rsp_rdata;
    assign silent_count = q.silent_cnt;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
    parameter int LADDR_W = 6,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               mem_valid,
    input logic               mem_write,
    input logic               mem_ack,
    input logic [LADDR_W-1:0] mem_line_addr,
    input logic [CNT_W-1:0]   silent_count
);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_write) && $stable(mem_line_addr)));

    // R7
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && mem_ack) |=> (mem_valid && !mem_write));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R4
    silent_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(silent_count) |-> (rsp_valid && silent_count == $past(silent_count) + 1'b1));

    // R8
    no_mem_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_valid);
endmodule

bind silent_store_cache ssc_checker #(
    .LADDR_W(ADDR_W - OFF_W),
    .CNT_W  (CNT_W)
) i_ssc_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mem_valid    (mem_valid),
    .mem_write    (mem_write),
    .mem_ack      (mem_ack),
    .mem_line_addr(mem_line_addr),
    .silent_count (silent_count)
);

// File: tb/test_silent_store_cache.sv
module test_silent_store_cache;
    localparam int ADDR_W  = 10;
    localparam int WORD_W  = 32;
    localparam int LWORDS  = 4;
    localparam int SETS    = 2;
    localparam int CNT_W   = 16;
    localparam int LINE_W  = LWORDS * WORD_W;
    localparam int LADDR_W = ADDR_W - 4;
    localparam int NLINES  = 1 << LADDR_W;

    logic clk = 0;
    logic rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic [3:0] req_be = '0;
    logic req_ready, rsp_valid;
    logic [WORD_W-1:0] rsp_rdata;
    logic [CNT_W-1:0] silent_count;
    logic mem_valid, mem_write;
    logic [LADDR_W-1:0] mem_line_addr;
    logic [LINE_W-1:0] mem_wline;
    logic mem_ack = 0;
    logic [LINE_W-1:0] mem_rline = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    silent_store_cache #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LWORDS), .SETS(SETS), .CNT_W(CNT_W)
    ) i_silent_store_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .silent_count(silent_count),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_line_addr(mem_line_addr),
        .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline)
    );

    // Bench memory and behavioural model
    logic [LINE_W-1:0] mem [NLINES];
    bit                m_valid [SETS];
    bit                m_dirty [SETS];
    int                m_tag   [SETS];
    logic [LINE_W-1:0] m_line  [SETS];
    int                exp_silent = 0;

    // Memory traffic seen at the port: kind (1 = write), line address, data
    bit                got_kind [$];
    int                got_addr [$];
    logic [LINE_W-1:0] got_data [$];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] init_line(int i);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < LWORDS; w++)
            l[w*WORD_W +: WORD_W] = {i[7:0], w[7:0], 8'hA5, 8'h3C};
        return (i % 8 == 6) ? '0 : l;
    endfunction

    // Memory responder: acknowledges after two idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_valid && !mem_ack && !rst) begin
                repeat (2) @(negedge clk);
                got_kind.push_back(mem_write);
                got_addr.push_back(int'(mem_line_addr));
                if (mem_write) begin
                    got_data.push_back(mem_wline);
                    mem[mem_line_addr] = mem_wline;
                end else begin
                    mem_rline = mem[mem_line_addr];
                end
                mem_ack = 1;
                @(negedge clk);
                mem_ack = 0;
            end
        end
    end

    // Peek the value the model holds for an address
    function automatic logic [WORD_W-1:0] peek(logic [ADDR_W-1:0] a);
        int ix = int'(a[4]);
        int tg = int'(a[9:5]);
        logic [LINE_W-1:0] l;
        l = (m_valid[ix] && m_tag[ix] == tg) ? m_line[ix] : mem[a[9:4]];
        return l[a[3:2]*WORD_W +: WORD_W];
    endfunction

    task automatic op(bit wr, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] wd, logic [3:0] be,
                      string req);
        int ix = int'(a[4]);
        int tg = int'(a[9:5]);
        int w  = int'(a[3:2]);
        bit hit = m_valid[ix] && m_tag[ix] == tg;
        bit                exp_kind [$];
        int                exp_addr [$];
        logic [LINE_W-1:0] exp_wb   [$];
        logic [WORD_W-1:0] old_w, new_w, exp_rd;
        int cyc;
        if (!hit) begin
            if (m_valid[ix] && m_dirty[ix]) begin
                exp_kind.push_back(1);
                exp_addr.push_back(m_tag[ix] * 2 + ix);
                exp_wb.push_back(m_line[ix]);
            end
            exp_kind.push_back(0);
            exp_addr.push_back(tg * 2 + ix);
            m_line[ix]  = mem[a[9:4]];
            m_valid[ix] = 1;
            m_tag[ix]   = tg;
            m_dirty[ix] = 0;
        end
        old_w = m_line[ix][w*WORD_W +: WORD_W];
        exp_rd = old_w;
        if (wr) begin
            new_w = old_w;
            for (int b = 0; b < 4; b++) if (be[b]) new_w[b*8 +: 8] = wd[b*8 +: 8];
            if (new_w != old_w) m_dirty[ix] = 1;
            else exp_silent++;
            m_line[ix][w*WORD_W +: WORD_W] = new_w;
        end
        got_kind.delete(); got_addr.delete(); got_data.delete();
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        cyc = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            cyc++;
        end
        if (hit) check(cyc == (wr ? 3 : 2), wr ? "R2" : "R1", "hit latency", cyc, wr ? 3 : 2);
        if (!wr) check(rsp_rdata == exp_rd, req, "load data", rsp_rdata, exp_rd);
        check(silent_count == exp_silent[CNT_W-1:0], wr ? req : "R4", "silent count",
              silent_count, exp_silent);
        check(got_kind.size() == exp_kind.size(), req, "memory request count",
              got_kind.size(), exp_kind.size());
        if (got_kind.size() == exp_kind.size()) begin
            for (int k = 0; k < exp_kind.size(); k++) begin
                check(got_kind[k] == exp_kind[k], exp_kind[0] ? "R7" : "R8", "request kind",
                      got_kind[k], exp_kind[k]);
                check(got_addr[k] == exp_addr[k], exp_kind[0] ? "R7" : "R8", "line address",
                      got_addr[k], exp_addr[k]);
            end
            if (exp_wb.size() == 1 && got_data.size() == 1)
                check(got_data[0] == exp_wb[0], "R3", "write-back data",
                      longint'(got_data[0][63:0]), longint'(exp_wb[0][63:0]));
        end
        @(negedge clk);
        check(!rsp_valid, "R1", "response pulse width", rsp_valid, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] ra;
        logic [WORD_W-1:0] rd;
        for (int i = 0; i < NLINES; i++) mem[i] = init_line(i);
        for (int s = 0; s < SETS; s++) begin
            m_valid[s] = 0; m_dirty[s] = 0; m_tag[s] = 0; m_line[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state
        check(req_ready == 1, "R9", "ready after reset", req_ready, 1);
        check(rsp_valid == 0, "R9", "rsp after reset", rsp_valid, 0);
        check(mem_valid == 0, "R9", "mem request after reset", mem_valid, 0);
        check(silent_count == 0, "R9", "counter after reset", silent_count, 0);

        // R8: clean miss refills only; R1: then a hit load
        op(0, 10'h000, '0, 4'h0, "R8");
        op(0, 10'h00C, '0, 4'h0, "R1");
        // R4: identical store, then evict with no write-back
        op(1, 10'h004, peek(10'h004), 4'hF, "R4");
        op(0, 10'h020, '0, 4'h0, "R4");
        // R3: changing store, R7: eviction writes back merged line
        op(1, 10'h024, 32'h0000_00EE, 4'h1, "R3");
        op(0, 10'h000, '0, 4'h0, "R7");
        // R5: differs only in disabled lanes -> silent, no write-back on eviction
        op(1, 10'h000, {16'hFFFF, peek(10'h000)[15:0]}, 4'h3, "R5");
        op(0, 10'h020, '0, 4'h0, "R5");
        // R6: zeros into an all-zero line -> silent, no write-back
        op(1, 10'h068, 32'h0, 4'hF, "R6");
        op(1, 10'h06C, 32'h0, 4'h6, "R6");
        op(0, 10'h000, '0, 4'h0, "R6");
        // R3/R4/R5/R7/R8 under random patterns
        for (int n = 0; n < 120; n++) begin
            ra = {$urandom_range(0, 7) == 7 ? 6'd6 : 6'($urandom_range(0, 7)),
                  2'($urandom_range(0, 3)), 2'b00};
            rd = ($urandom_range(0, 1) == 1) ? peek(ra) : $urandom;
            if ($urandom_range(0, 2) == 0) op(0, ra, '0, 4'h0, "R1");
            else op(1, ra, rd, 4'($urandom_range(0, 15)), "R3");
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule